// File: doc/BRIEF.md
# Green Mode and Soft-Start Sequencer

This block is the mode controller shared by both gate channels of a synchronous-rectifier controller. It decides when the gate drivers may switch at all, and whether they drive at the full or the reduced gate level. After the supply comes up, it suppresses gating for a fixed number of drain switching cycles. It then lets gating start at the reduced level and hands over to normal running once the start-up condition is met.

While running, an idle timer watches the conduction flags of both channels. A short idle stretch produces one preparation pulse, which downstream logic uses to reset the turn-off threshold regulator and raise the turn-on delay flag. A longer idle stretch moves the block into a low-power green state with the gate disabled. The green state is left after a fixed number of channel-1 drain-high edges. A fault input forces the green state at once, so that a few gate cycles are skipped.

In the running state, the gate level is chosen from three conditions: the light-load code, the measured switching period and a filtered over-temperature flag. A separate hard over-temperature input blocks the gate outright.

States:
- `ST_OFF`: supply not ready.
- `ST_SKIP`: counting start-up edges with the gate off.
- `ST_SOFT`: gate on at the reduced level.
- `ST_RUN`: normal operation.
- `ST_GREEN`: idle or fault, with the gate off.

Transitions:
- OFF→SKIP when the supply is ready.
- SKIP→SOFT after `SKIP_EDGES` edges.
- SOFT→RUN when the load code is 0 (load-based mode) or after `SOFT_EDGES` edges (fixed mode).
- SOFT/RUN→GREEN on long idle or on fault.
- GREEN→RUN after `EXIT_EDGES` edges.
- Any state→OFF when the supply drops.

Top module: `green_softstart_seq`

## Requirements
- R1: While `supply_ok` is low, including after reset, `gate_en`, `green`, `prep_pulse` and `lvl_high` are all 0. Dropping `supply_ok` returns the block to the off state on the next clock.
- R2: After `supply_ok` rises, `gate_en` stays 0 until `SKIP_EDGES` (256) pulses have been seen on `drain_hi_edge`. It then becomes 1.
- R3: After skipping, gating starts with `lvl_high` = 0. With `LOAD_LVL_EN` = 1, the reduced level holds for as long as `load_code` is non-zero, however many edges arrive.
- R4: With `LOAD_LVL_EN` = 0, the reduced level holds for `SOFT_EDGES` (256) further edges, independent of `load_code`. Full level follows after that.
- R5: When both conduction flags have been low for `PREP_CYC` clocks in the soft or run state, `prep_pulse` is 1 for exactly one clock. Only one pulse is issued per idle stretch.
- R6: When both conduction flags have been low for `GREEN_CYC` clocks, `green` becomes 1 and `gate_en` becomes 0.
- R7: Any high level or edge on either conduction flag restarts the idle timer from zero.
- R8: The green state is left, with `gate_en` back to 1, after `EXIT_EDGES` (4) pulses on `drain_hi_edge`.
- R9: `fault` high in the soft or run state forces `green` on the next clock. In the green state, `fault` restarts the exit count.
- R10: In the run state, `lvl_high` goes to 0 when `load_code` changes from 0 to 1. It stays 0 until `load_code` is 0 again.
- R11: In the run state, `lvl_high` is 0 while `period_cyc` is below `HFS_CYC` (500).
- R12: `lvl_high` is 0 while `ovt_soft` is 1.
- R13: `ovt_hard` high forces `gate_en` to 0 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply is above the gate-enable level |
| cond1 | input | 1 | Channel 1 conduction flag |
| cond2 | input | 1 | Channel 2 conduction flag |
| drain_hi_edge | input | 1 | One-clock pulse per channel-1 drain-high rise |
| load_code | input | 2 | Light-load code (0 = normal load) |
| period_cyc | input | PER_W | Last measured switching period, in clocks |
| ovt_soft | input | 1 | Filtered over-temperature flag (reduce level) |
| ovt_hard | input | 1 | Hard over-temperature flag (gate off) |
| fault | input | 1 | Shutdown or abnormal drain-sensing fault |
| gate_en | output | 1 | Gate drivers allowed to switch |
| prep_pulse | output | 1 | One-clock idle preparation pulse |
| green | output | 1 | Low-power green state |
| lvl_high | output | 1 | 1 = full gate level, 0 = reduced |

## Verification
The assertions assume three things about the inputs:
- `drain_hi_edge` is a single-clock pulse, so one input cycle counts once.
- `ovt_soft` is already debounced.
- `period_cyc` holds a valid measurement whenever the block is running.

The stimulus meets these assumptions:
- Every edge is driven as one high clock followed by a low clock.
- The period is held at a settled value and changed only between checks.
- Conduction flags are held high whenever idle timing must not interfere, and dropped only in the idle tests.

// File: rtl/gms_pkg.sv
package gms_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_SKIP  = 3'd1,
        ST_SOFT  = 3'd2,
        ST_RUN   = 3'd3,
        ST_GREEN = 3'd4
    } gms_state_e;
endpackage

// File: rtl/gms_evt_cnt.sv
module gms_evt_cnt #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (clr)                   cnt_q <= '0;
        else if (inc && cnt_q != limit) cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == limit);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> cnt_q == '0);
endmodule

// File: rtl/gms_idle_timer.sv
module gms_idle_timer #(
    parameter int PREP_CYC  = 600,
    parameter int GREEN_CYC = 6000,
    localparam int TW = $clog2(GREEN_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic cond1,
    input  logic cond2,
    output logic prep_hit,
    output logic green_hit
);
    logic [TW-1:0] idle_q;
    logic          c1_q, c2_q;
    logic          busy;

    assign busy = cond1 | cond2 | c1_q | c2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
            c1_q   <= 1'b0;
            c2_q   <= 1'b0;
        end else begin
            c1_q <= cond1;
            c2_q <= cond2;
            if (!active || busy)
                idle_q <= '0;
            else if (idle_q != TW'(GREEN_CYC))
                idle_q <= idle_q + 1'b1;
        end
    end

    assign prep_hit  = active && (idle_q == TW'(PREP_CYC));
    assign green_hit = active && (idle_q == TW'(GREEN_CYC));

    // R5
    prep_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prep_hit |=> !prep_hit);
    // R7
    idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond1 || cond2) |=> !prep_hit && !green_hit);
endmodule

// File: rtl/gms_level_sel.sv
module gms_level_sel #(
    parameter int PER_W   = 16,
    parameter int HFS_CYC = 500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       load_code,
    input  logic [PER_W-1:0] period_cyc,
    input  logic             ovt_soft,
    output logic             lvl_high
);
    logic [1:0] code_q;
    logic       load_low_q;
    logic       short_per;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q     <= 2'd0;
            load_low_q <= 1'b0;
        end else begin
            code_q <= load_code;
            if (load_code == 2'd0)
                load_low_q <= 1'b0;
            else if (code_q == 2'd0 && load_code == 2'd1)
                load_low_q <= 1'b1;
        end
    end

    assign short_per = (period_cyc < PER_W'(HFS_CYC));
    assign lvl_high  = run && !load_low_q && !short_per && !ovt_soft;

    // R10
    load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_q) == 2'd0 && $past(load_code) == 2'd1 && load_code != 2'd0) |-> !lvl_high);
endmodule

// File: rtl/green_softstart_seq.sv
module green_softstart_seq
    import gms_pkg::*;
#(
    parameter int PER_W       = 16,
    parameter int SKIP_EDGES  = 256,
    parameter int SOFT_EDGES  = 256,
    parameter int EXIT_EDGES  = 4,
    parameter int PREP_CYC    = 600,
    parameter int GREEN_CYC   = 6000,
    parameter int HFS_CYC     = 500,
    parameter bit LOAD_LVL_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             cond1,
    input  logic             cond2,
    input  logic             drain_hi_edge,
    input  logic [1:0]       load_code,
    input  logic [PER_W-1:0] period_cyc,
    input  logic             ovt_soft,
    input  logic             ovt_hard,
    input  logic             fault,
    output logic             gate_en,
    output logic             prep_pulse,
    output logic             green,
    output logic             lvl_high
);
    localparam int MAXE = (SKIP_EDGES > SOFT_EDGES) ? SKIP_EDGES : SOFT_EDGES;
    localparam int CW   = $clog2(((MAXE > EXIT_EDGES) ? MAXE : EXIT_EDGES) + 1);

    gms_state_e    state_q, state_nx;
    logic [CW-1:0] limit;
    logic          cnt_clr, cnt_done;
    logic          idle_act, prep_hit, green_hit;
    logic          soft_done;

    always_comb begin
        unique case (state_q)
            ST_SKIP:  limit = CW'(SKIP_EDGES);
            ST_SOFT:  limit = CW'(SOFT_EDGES);
            ST_GREEN: limit = CW'(EXIT_EDGES);
            default:  limit = '0;
        endcase
    end

    assign cnt_clr  = (state_nx != state_q) || (state_q == ST_GREEN && fault);
    assign idle_act = (state_q == ST_SOFT) || (state_q == ST_RUN);

    generate
        if (LOAD_LVL_EN) begin : g_load_exit
            assign soft_done = (load_code == 2'd0);
        end else begin : g_count_exit
            assign soft_done = cnt_done;
        end
    endgenerate

    gms_evt_cnt #(.CW(CW)) u_edges (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(drain_hi_edge),
        .limit(limit), .done(cnt_done)
    );

    gms_idle_timer #(.PREP_CYC(PREP_CYC), .GREEN_CYC(GREEN_CYC)) u_idle (
        .clk(clk), .rst_n(rst_n), .active(idle_act), .cond1(cond1),
        .cond2(cond2), .prep_hit(prep_hit), .green_hit(green_hit)
    );

    gms_level_sel #(.PER_W(PER_W), .HFS_CYC(HFS_CYC)) u_lvl (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_RUN),
        .load_code(load_code), .period_cyc(period_cyc),
        .ovt_soft(ovt_soft), .lvl_high(lvl_high)
    );

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF:   if (supply_ok) state_nx = ST_SKIP;
            ST_SKIP:  if (cnt_done) state_nx = ST_SOFT;
            ST_SOFT:  if (fault || green_hit) state_nx = ST_GREEN;
                      else if (soft_done) state_nx = ST_RUN;
            ST_RUN:   if (fault || green_hit) state_nx = ST_GREEN;
            ST_GREEN: if (cnt_done && !fault) state_nx = ST_RUN;
            default:  state_nx = ST_OFF;
        endcase
        if (!supply_ok) state_nx = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_nx;
    end

    always_comb begin
        gate_en    = supply_ok && !ovt_hard &&
                     (state_q == ST_SOFT || state_q == ST_RUN);
        green      = (state_q == ST_GREEN);
        prep_pulse = prep_hit;
    end

    // R6
    green_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        green |-> !gate_en);
    // R13
    hard_ot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovt_hard |-> !gate_en);
    // R9
    fault_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && supply_ok && state_q == ST_RUN) |=> green);
    // R1
    supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !green && !lvl_high && !prep_pulse);
    // R11
    short_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_cyc < PER_W'(HFS_CYC)) |-> !lvl_high);
    // R12
    ovt_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovt_soft |-> !lvl_high);
endmodule

// File: tb/tb_green_softstart_seq.sv
module tb_green_softstart_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        supply_ok = 1'b0, cond1 = 1'b1, cond2 = 1'b0, drain_hi_edge = 1'b0;
    logic [1:0]  load_code = 2'd2;
    logic [15:0] period_cyc = 16'd1000;
    logic        ovt_soft = 1'b0, ovt_hard = 1'b0, fault = 1'b0;
    logic        gate_en, prep_pulse, green, lvl_high;
    logic        gate_en2, prep_pulse2, green2, lvl_high2;
    int          checks = 0, errors = 0;

    localparam int PREP = 600;
    localparam int GRN  = 6000;

    always #5 clk = ~clk;

    green_softstart_seq dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cond1(cond1), .cond2(cond2),
        .drain_hi_edge(drain_hi_edge), .load_code(load_code), .period_cyc(period_cyc),
        .ovt_soft(ovt_soft), .ovt_hard(ovt_hard), .fault(fault),
        .gate_en(gate_en), .prep_pulse(prep_pulse), .green(green), .lvl_high(lvl_high));

    green_softstart_seq #(.LOAD_LVL_EN(1'b0)) dut_fix (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cond1(cond1), .cond2(cond2),
        .drain_hi_edge(drain_hi_edge), .load_code(load_code), .period_cyc(period_cyc),
        .ovt_soft(ovt_soft), .ovt_hard(ovt_hard), .fault(fault),
        .gate_en(gate_en2), .prep_pulse(prep_pulse2), .green(green2), .lvl_high(lvl_high2));

    // llc[21:20] period[19:4] ovt_soft[3] ovt_hard[2] exp_gate[1] exp_lvl[0]
    localparam logic [21:0] VEC [8] = '{
        {2'd0, 16'd1000, 1'b0, 1'b0, 1'b1, 1'b1},  // R11 baseline
        {2'd0, 16'd400,  1'b0, 1'b0, 1'b1, 1'b0},  // R11 short period
        {2'd0, 16'd1000, 1'b1, 1'b0, 1'b1, 1'b0},  // R12
        {2'd0, 16'd1000, 1'b0, 1'b1, 1'b0, 1'b1},  // R13
        {2'd1, 16'd1000, 1'b0, 1'b0, 1'b1, 1'b0},  // R10 0->1
        {2'd2, 16'd1000, 1'b0, 1'b0, 1'b1, 1'b0},  // R10 held
        {2'd1, 16'd1000, 1'b0, 1'b0, 1'b1, 1'b0},  // R10 held
        {2'd0, 16'd1000, 1'b0, 1'b0, 1'b1, 1'b1}   // R10 release
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            drain_hi_edge = 1'b1;
            @(negedge clk);
            drain_hi_edge = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pcnt, pfirst, gfirst;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1 reset state
        chk(gate_en == 0 && green == 0 && prep_pulse == 0 && lvl_high == 0, "R1", gate_en, 0);

        supply_ok = 1'b1;
        cyc(2);
        edges(255);
        chk(gate_en == 0, "R2 before 256", gate_en, 0);
        edges(1);
        cyc(2);
        chk(gate_en == 1, "R2 after 256", gate_en, 1);
        chk(lvl_high == 0, "R3 soft level", lvl_high, 0);

        edges(255);
        chk(lvl_high2 == 0, "R4 before 256", lvl_high2, 0);
        edges(45);
        cyc(2);
        chk(lvl_high2 == 1, "R4 after 256", lvl_high2, 1);
        chk(lvl_high == 0 && gate_en == 1, "R3 held by load code", lvl_high, 0);

        load_code = 2'd0;
        cyc(3);
        chk(lvl_high == 1, "R3 release", lvl_high, 1);

        foreach (VEC[k]) begin
            load_code  = VEC[k][21:20];
            period_cyc = VEC[k][19:4];
            ovt_soft   = VEC[k][3];
            ovt_hard   = VEC[k][2];
            cyc(3);
            chk(gate_en == VEC[k][1], "R10-13 table gate", gate_en, VEC[k][1]);
            chk(lvl_high == VEC[k][0], "R10-13 table level", lvl_high, VEC[k][0]);
        end

        // R7: idle interrupted by a one-clock cond2 pulse
        cond1 = 1'b0;
        pcnt = 0;
        for (int i = 0; i < 500; i++) begin @(negedge clk); if (prep_pulse) pcnt++; end
        cond2 = 1'b1;
        @(negedge clk);
        cond2 = 1'b0;
        pcnt = 0; pfirst = -1; gfirst = -1;
        for (int i = 1; i <= GRN + 4; i++) begin
            @(negedge clk);
            if (prep_pulse) begin pcnt++; if (pfirst < 0) pfirst = i; end
            if (green && gfirst < 0) gfirst = i;
        end
        chk(pfirst == PREP + 1, "R7 restart", pfirst, PREP + 1);
        chk(pcnt == 1, "R5 single pulse", pcnt, 1);
        chk(gfirst == GRN + 2, "R6 green entry", gfirst, GRN + 2);
        chk(gate_en == 0, "R6 gate off", gate_en, 0);

        cond1 = 1'b1;
        edges(3);
        chk(green == 1, "R8 after 3", green, 1);
        edges(1);
        cyc(2);
        chk(green == 0 && gate_en == 1, "R8 exit", green, 0);

        fault = 1'b1;
        @(negedge clk);
        fault = 1'b0;
        @(negedge clk);
        chk(green == 1 && gate_en == 0, "R9 fault", green, 1);
        edges(4);
        cyc(2);
        chk(green == 0, "R9 skip 4", green, 0);

        supply_ok = 1'b0;
        cyc(2);
        chk(gate_en == 0 && green == 0 && lvl_high == 0, "R1 supply drop", gate_en, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule